// File: doc/BRIEF.md
# Handshaked Multiplexed Byte-Bus Register Slave

This block is the target side of a narrow, fully handshaked bus. The bus has one 8-bit bidirectional address/data path and four strobe lines from the master: a strobe, a read/write select and two byte-lane selects. The slave answers on a single acknowledge line. The slave runs from its own local clock and treats every master line as asynchronous. Each master line passes through a synchronizer before a synchronous state machine uses it.

A transfer starts with an address phase. The strobe is raised with both lane selects low, and the slave stores the byte on the bus as the current address. One or two data phases follow. In each one, a single lane select picks the high or low byte of the 16-bit word at that address. Three 16-bit words sit behind the slave. Word n occupies byte addresses 2n (its high byte) and 2n+1 (its low byte). The slave drives the shared path only while it returns read data. At every other time it leaves the path released.

Top module: `hsbus_slave`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), ack_o is low, ad_io is released (high impedance) and all three words read as 0x0000.
- R2: A phase with rdy_i high and both hbe_i and lbe_i low is an address phase. The slave stores the ad_io byte as the current address and raises ack_o when that address is in the range 0 to 5.
- R3: The handshake is four-phase. ack_o rises no earlier than the third clock edge after rdy_i rises, stays high for as long as rdy_i stays high, and falls only after rdy_i has fallen.
- R4: A data phase with rw_i low (write) and exactly one lane select high stores the ad_io byte into one byte of the word addressed by address bits [7:1]. hbe_i selects bits [15:8] and lbe_i selects bits [7:0]. The other byte of the word keeps its value, and ack_o is raised.
- R5: A data phase with rw_i high (read) and exactly one lane select high drives the selected byte onto ad_io. The byte is on the bus before ack_o rises and stays on the bus while ack_o is high and rdy_i is high.
- R6: ad_io is released at every time except during a read data phase. After a read, it is released before ack_o falls.
- R7: An address from 6 to 255 is never acknowledged. The data phases that follow it are also never acknowledged, and their writes change no word.
- R8: A data phase with both hbe_i and lbe_i high is not acknowledged and writes nothing.
- R9: Byte access is chosen by the lane select. The even byte address (hbe_i) returns the high byte and the odd byte address (lbe_i) returns the low byte. A word access is an address phase followed by a high phase and then a low phase.
- R10: The stored address remains in force for any number of data phases, until the next address phase replaces it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock of the slave |
| rst_n | input | 1 | Synchronous reset, active low |
| rdy_i | input | 1 | Master strobe, asynchronous |
| rw_i | input | 1 | 1 = read, 0 = write, asynchronous |
| hbe_i | input | 1 | High byte lane select, asynchronous |
| lbe_i | input | 1 | Low byte lane select, asynchronous |
| ack_o | output | 1 | Slave acknowledge |
| ad_io | inout | 8 | Multiplexed address/data path |

## Verification
The bench acts as the master, with a weak pull-up on the shared path. A release check therefore reads 0xFF, while a slave that keeps driving too long puts its own byte on the path instead. The directed cases cover the following:
- Addresses just past the map, and high addresses that would alias onto word 0 if the upper address bits were dropped. A slave that decodes only the low address bits would acknowledge these or corrupt word 0.
- A phase with both lane selects high, which a careless decoder would treat as a high-byte write.
- A strobe held high long after the acknowledge. A slave that times out instead of waiting would drop ack_o early.
- Repeated reads under a single address, which a slave that clears its address after one phase would fail.

Seeded random byte and word traffic, compared against a model of the word contents, exposes swapped lanes and writes that touch the wrong byte.

// File: rtl/hsbus_pkg.sv
// Package: shared state encoding and strobe bundle for the handshaked byte-bus slave.
// Assumes: one byte-wide multiplexed path and four master strobes.
package hsbus_pkg;

    // Handshake controller states
    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,  // waiting for a strobe
        ST_ACK_HOLD   = 3'd1,  // acknowledged, waiting for strobe to fall
        ST_SILENT     = 3'd2,  // refused, waiting for strobe to fall
        ST_RD_DRIVE   = 3'd3,  // read byte placed on path, ack not yet up
        ST_RD_ACK     = 3'd4,  // read byte on path with ack up
        ST_RD_RELEASE = 3'd5   // path released, ack still up for one cycle
    } hs_state_t;

    // Synchronized master strobes
    typedef struct packed {
        logic rdy;
        logic rw;
        logic hbe;
        logic lbe;
    } hs_ctrl_t;

    localparam int CTRL_W = $bits(hs_ctrl_t);

endpackage

// File: rtl/hsbus_sync.sv
// Module: multi-stage synchronizer for asynchronous master strobes.
// Assumes: each bit is independent; reset clears all stages to 0 so the
// controller sees an idle bus after reset.
module hsbus_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    // Shift the raw strobes through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/hsbus_regfile.sv
// Module: word-organised register file with byte write and byte read.
// Assumes: word index comes from address bits [7:1]; indices at or beyond
// NUM_WORDS are never written and read as zero.
module hsbus_regfile #(
    parameter int NUM_WORDS = 3,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_hi_i,
    input  logic [BYTE_W-2:0] wr_word_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [BYTE_W-2:0] rd_word_i,
    input  logic              rd_lo_i,
    output logic [BYTE_W-1:0] rd_data_o
);

    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] mem [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        // Byte-lane write into word i
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr_en_i && (32'(wr_word_i) == i)) begin
                if (wr_hi_i) mem[i][WORD_W-1:BYTE_W] <= wr_data_i;
                else         mem[i][BYTE_W-1:0]      <= wr_data_i;
            end
        end
    end

    // Select the addressed byte for the read path
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (32'(rd_word_i) == i)
                rd_data_o = rd_lo_i ? mem[i][BYTE_W-1:0] : mem[i][WORD_W-1:BYTE_W];
        end
    end

    assert_wr_mapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (32'(wr_word_i) < NUM_WORDS));

endmodule

// File: rtl/hsbus_fsm.sv
// Module: four-phase handshake controller for the multiplexed byte bus.
// Assumes: strobes arrive already synchronized; the master holds the path
// and strobes stable from before the strobe rises until ack falls.
module hsbus_fsm
    import hsbus_pkg::*;
#(
    parameter int NUM_WORDS = 3,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  hs_ctrl_t          ctrl_i,
    input  logic [BYTE_W-1:0] ad_in_i,
    output logic              ack_o,
    output logic              drive_en_o,
    output logic              wr_en_o,
    output logic              wr_hi_o,
    output logic [BYTE_W-2:0] word_o,
    output logic              rd_lo_o
);

    localparam int BYTE_SPAN = 2 * NUM_WORDS;

    hs_state_t         state_q, state_d;
    logic [BYTE_W-1:0] addr_q;
    logic              addr_ok_q;
    logic              lane_lo_q;

    logic addr_phase, one_lane, data_ok, ad_mapped;

    // Classify the current phase from the synchronized strobes
    always_comb begin
        addr_phase = ctrl_i.rdy && !ctrl_i.hbe && !ctrl_i.lbe;
        one_lane   = ctrl_i.hbe ^ ctrl_i.lbe;
        data_ok    = ctrl_i.rdy && one_lane && addr_ok_q;
        ad_mapped  = 32'(ad_in_i) < BYTE_SPAN;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_phase)
                    state_d = ad_mapped ? ST_ACK_HOLD : ST_SILENT;
                else if (data_ok)
                    state_d = ctrl_i.rw ? ST_RD_DRIVE : ST_ACK_HOLD;
                else if (ctrl_i.rdy)
                    state_d = ST_SILENT;
            end
            ST_ACK_HOLD:   if (!ctrl_i.rdy) state_d = ST_IDLE;
            ST_SILENT:     if (!ctrl_i.rdy) state_d = ST_IDLE;
            ST_RD_DRIVE:   state_d = ST_RD_ACK;
            ST_RD_ACK:     if (!ctrl_i.rdy) state_d = ST_RD_RELEASE;
            ST_RD_RELEASE: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // State, address and lane registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            addr_ok_q <= 1'b0;
            lane_lo_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && addr_phase) begin
                addr_q    <= ad_in_i;
                addr_ok_q <= ad_mapped;
            end
            if (state_q == ST_IDLE && data_ok)
                lane_lo_q <= ctrl_i.lbe;
        end
    end

    // Decode outputs from the registered state
    always_comb begin
        ack_o      = (state_q == ST_ACK_HOLD) || (state_q == ST_RD_ACK) ||
                     (state_q == ST_RD_RELEASE);
        drive_en_o = (state_q == ST_RD_DRIVE) || (state_q == ST_RD_ACK);
        wr_en_o    = (state_q == ST_IDLE) && data_ok && !ctrl_i.rw;
        wr_hi_o    = ctrl_i.hbe;
        word_o     = addr_q[BYTE_W-1:1];
        rd_lo_o    = lane_lo_q;
    end

    assert_ack_falls_after_rdy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_o) |-> !$past(ctrl_i.rdy));

    assert_ack_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> $past(ctrl_i.rdy));

    assert_ack_only_mapped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_o) |-> addr_ok_q);

endmodule

// File: rtl/hsbus_slave.sv
// Module: top of the handshaked multiplexed byte-bus slave.
// Assumes: all master lines are asynchronous to clk; ad_io is shared with
// the master and is driven here only while read data is returned.
module hsbus_slave
    import hsbus_pkg::*;
#(
    parameter int NUM_WORDS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rdy_i,
    input  logic       rw_i,
    input  logic       hbe_i,
    input  logic       lbe_i,
    output logic       ack_o,
    inout  wire  [7:0] ad_io
);

    localparam int BYTE_W = 8;

    hs_ctrl_t          ctrl_raw, ctrl_s;
    logic [CTRL_W-1:0] ctrl_s_bits;
    logic              drive_en, wr_en, wr_hi, rd_lo;
    logic [BYTE_W-2:0] word_idx;
    logic [BYTE_W-1:0] rd_byte;

    // Bundle the raw strobes
    always_comb begin
        ctrl_raw.rdy = rdy_i;
        ctrl_raw.rw  = rw_i;
        ctrl_raw.hbe = hbe_i;
        ctrl_raw.lbe = lbe_i;
    end

    hsbus_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctrl_raw),
        .q_o   (ctrl_s_bits)
    );

    assign ctrl_s = hs_ctrl_t'(ctrl_s_bits);

    hsbus_fsm #(.NUM_WORDS(NUM_WORDS), .BYTE_W(BYTE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl_s),
        .ad_in_i    (ad_io),
        .ack_o      (ack_o),
        .drive_en_o (drive_en),
        .wr_en_o    (wr_en),
        .wr_hi_o    (wr_hi),
        .word_o     (word_idx),
        .rd_lo_o    (rd_lo)
    );

    hsbus_regfile #(.NUM_WORDS(NUM_WORDS), .BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_hi_i   (wr_hi),
        .wr_word_i (word_idx),
        .wr_data_i (ad_io),
        .rd_word_i (word_idx),
        .rd_lo_i   (rd_lo),
        .rd_data_o (rd_byte)
    );

    // Tri-state driver for the shared path
    assign ad_io = drive_en ? rd_byte : 8'hzz;

    assert_drive_before_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && drive_en) |-> $past(drive_en));

    assert_release_before_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en) |-> ack_o);

endmodule

// File: tb/hsbus_slave_tb.sv
module hsbus_slave_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, rdy, rw, hbe, lbe, m_oe;
    logic [7:0] m_dat;
    wire        ack;
    wire  [7:0] ad_bus;

    assign ad_bus = m_oe ? m_dat : 8'hzz;
    for (genvar i = 0; i < 8; i++) begin : g_pull
        pullup (ad_bus[i]);
    end

    hsbus_slave u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .rdy_i (rdy),
        .rw_i  (rw),
        .hbe_i (hbe),
        .lbe_i (lbe),
        .ack_o (ack),
        .ad_io (ad_bus)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [15:0] model [3];

    task automatic check(input logic ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [7:0] a, input logic lo);
        logic [15:0] w;
        w = model[a[2:1]];
        return lo ? w[7:0] : w[15:8];
    endfunction

    task automatic wait_ack(output logic got);
        got = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (ack) begin got = 1'b1; break; end
        end
    endtask

    task automatic wait_drop();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (!ack) break;
        end
        check(!ack, "R3 ack drop", 16'(ack), 16'd0);
    endtask

    task automatic end_phase(input logic got);
        rdy = 1'b0;
        if (got) wait_drop();
        else repeat (4) @(negedge clk);
        m_oe = 1'b0; hbe = 1'b0; lbe = 1'b0; rw = 1'b1;
        @(negedge clk);
        check(ad_bus == 8'hFF, "R6 released", 16'(ad_bus), 16'hFF);
    endtask

    task automatic addr_phase(input logic [7:0] a, input logic exp_ack);
        logic got;
        @(negedge clk);
        rw = 1'b1; hbe = 1'b0; lbe = 1'b0; m_dat = a; m_oe = 1'b1;
        @(negedge clk);
        rdy = 1'b1;
        wait_ack(got);
        check(got == exp_ack, exp_ack ? "R2 addr ack" : "R7 unmapped silent",
              16'(got), 16'(exp_ack));
        end_phase(got);
    endtask

    task automatic data_phase(input logic wr, input logic h, input logic l,
                              input logic [7:0] wd, input logic exp_ack,
                              input logic [7:0] exp_rd, input string req);
        logic got;
        @(negedge clk);
        rw = !wr; hbe = h; lbe = l; m_oe = wr; m_dat = wd;
        @(negedge clk);
        rdy = 1'b1;
        wait_ack(got);
        check(got == exp_ack, req, 16'(got), 16'(exp_ack));
        if (got && !wr) begin
            check(ad_bus == exp_rd, "R5 read data", 16'(ad_bus), 16'(exp_rd));
            @(negedge clk);
            check(ad_bus == exp_rd, "R5 read held", 16'(ad_bus), 16'(exp_rd));
        end
        end_phase(got);
    endtask

    task automatic byte_access(input logic [7:0] a, input logic wr, input logic [7:0] wd);
        logic ok;
        ok = a < 8'd6;
        addr_phase(a, ok);
        data_phase(wr, !a[0], a[0], wd, ok, ok ? exp_byte(a, a[0]) : 8'h00,
                   wr ? "R4 byte write" : "R9 byte read");
        if (ok && wr) begin
            if (a[0]) model[a[2:1]][7:0]  = wd;
            else      model[a[2:1]][15:8] = wd;
        end
    endtask

    task automatic word_access(input logic [7:0] a, input logic wr, input logic [15:0] wd);
        logic ok;
        ok = a < 8'd6;
        addr_phase(a, ok);
        data_phase(wr, 1'b1, 1'b0, wd[15:8], ok, ok ? exp_byte(a, 1'b0) : 8'h00,
                   "R9 word high");
        if (ok && wr) model[a[2:1]][15:8] = wd[15:8];
        data_phase(wr, 1'b0, 1'b1, wd[7:0], ok, ok ? exp_byte(a, 1'b1) : 8'h00,
                   "R10 word low same address");
        if (ok && wr) model[a[2:1]][7:0] = wd[7:0];
    endtask

    task automatic read_all(input string req);
        for (int w = 0; w < 3; w++) begin
            addr_phase(8'(2 * w), 1'b1);
            data_phase(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, model[w][15:8], req);
            data_phase(1'b0, 1'b0, 1'b1, 8'h00, 1'b1, model[w][7:0], req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic got;
        void'($urandom(32'h1D2C3B4A));
        rst_n = 1'b0; rdy = 1'b0; rw = 1'b1; hbe = 1'b0; lbe = 1'b0;
        m_oe = 1'b0; m_dat = 8'h00;
        for (int w = 0; w < 3; w++) model[w] = 16'h0000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!ack, "R1 ack low", 16'(ack), 16'd0);
        check(ad_bus == 8'hFF, "R1 path released", 16'(ad_bus), 16'hFF);
        read_all("R1 zero after reset");

        // R3: early ack and hold while strobe stays high
        @(negedge clk);
        m_dat = 8'h02; m_oe = 1'b1; hbe = 1'b0; lbe = 1'b0;
        @(negedge clk);
        rdy = 1'b1;
        @(negedge clk);
        check(!ack, "R3 no early ack", 16'(ack), 16'd0);
        wait_ack(got);
        repeat (10) @(negedge clk);
        check(ack, "R3 ack held", 16'(ack), 16'd1);
        end_phase(got);

        // R4: byte writes keep the other lane
        word_access(8'h02, 1'b1, 16'hA55A);
        byte_access(8'h03, 1'b1, 8'h3C);
        byte_access(8'h02, 1'b0, 8'h00);
        byte_access(8'h03, 1'b0, 8'h00);

        // R10: repeated reads under one address
        word_access(8'h04, 1'b1, 16'h1234);
        addr_phase(8'h04, 1'b1);
        for (int k = 0; k < 3; k++)
            data_phase(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h12, "R10 repeat read");

        // R8: both lanes selected
        addr_phase(8'h02, 1'b1);
        data_phase(1'b1, 1'b1, 1'b1, 8'hEE, 1'b0, 8'h00, "R8 both lanes silent");
        read_all("R8 no write");

        // R7: unmapped and aliasing addresses
        word_access(8'h06, 1'b1, 16'hDEAD);
        word_access(8'h80, 1'b1, 16'hBEEF);
        byte_access(8'hFF, 1'b1, 8'h77);
        read_all("R7 no write");

        // Random traffic
        for (int n = 0; n < 200; n++) begin
            logic [7:0] a;
            logic       wr;
            a  = 8'($urandom % 8);
            wr = 1'($urandom);
            if ($urandom % 2 == 0) word_access({a[7:1], 1'b0}, wr, 16'($urandom));
            else                   byte_access(a, wr, 8'($urandom));
        end
        read_all("R9 final contents");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule